// File: doc/BRIEF.md
# ROM Bank Chip-Select Decoder

This block sits between a processor with a 20-bit byte address and an 8-bit data bus and four read-only banks of 32K x 8 each. Together the banks fill the highest 128 KB of the 1 MB space, from 0xE0000 up to 0xFFFFF. The three top address bits act as a region qualifier. The next two bits choose one of four banks through a gated 2-to-4 decoder. The low fifteen bits go to every bank unchanged as the in-bank offset.

The processor's active-low read strobe drives the output enable of all four banks in parallel. A bank puts its byte on the data bus only while its chip select and its output enable are both low. The bank contents are behavioural and computed from a constant function of bank number and offset. The shared bus is modelled as a data word plus a drive-enable, as a pad would use it. When the drive-enable is low the bus counts as released and the data word is held at zero. Everything is combinational from address and strobe.

Top module: `rom_bank_decoder`

## Requirements
- R1: `bank_addr_o` always equals `addr_i[14:0]`, whatever the upper address bits or the strobe.
- R2: `cs_no[k]` is low exactly when `addr_i[19:17]` is 3'b111 and `addr_i[16:15]` equals k (bank 0 at 0xE0000-0xE7FFF, bank 1 at 0xE8000-0xEFFFF, bank 2 at 0xF0000-0xF7FFF, bank 3 at 0xF8000-0xFFFFF).
- R3: At most one bit of `cs_no` is low at any time, and all four are high for any address below 0xE0000.
- R4: Every bit of `oe_no` equals `rd_ni`, independent of the address.
- R5: `data_oe_o` is 1 exactly when `rd_ni` is 0 and some bit of `cs_no` is 0.
- R6: While `data_oe_o` is 1, `data_o` holds the byte of the selected bank b at offset o = `addr_i[14:0]`. That byte is ((o[7:0] XOR {1'b0, o[14:8]}) + 8'h47 * b) mod 256.
- R7: While `data_oe_o` is 0, the bus is released and `data_o` is 8'h00. This holds for a read outside the region and for any address with `rd_ni` high.
- R8: The last byte of a bank and the first byte of the next bank come from different banks (0xE7FFF vs 0xE8000, 0xEFFFF vs 0xF0000, 0xF7FFF vs 0xF8000). 0xDFFFF selects nothing, and 0xFFFFF selects bank 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 20 | Processor byte address |
| rd_ni | input | 1 | Read strobe, active low |
| cs_no | output | 4 | Per-bank chip selects, active low |
| oe_no | output | 4 | Per-bank output enables, active low |
| bank_addr_o | output | 15 | In-bank offset shared by all banks |
| data_o | output | 8 | Byte returned to the processor |
| data_oe_o | output | 1 | High while the block drives the data bus |

## Verification
There is no internal state, so any fault in the decode shows at the ports as soon as the address or strobe settles. A wrong select bit shows up in one of two ways. Either two chip selects are low at once, or a read returns a byte whose bank term (multiples of 8'h47) is wrong. Those errors are seen on the very access that crosses the faulty boundary. A faulty enable gate shows up as a driven bus outside the region or with the strobe high. The bench therefore probes each bank edge on both sides and reads with the strobe deasserted.

// File: rtl/rom_dec_pkg.sv
package rom_dec_pkg;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 8;
  localparam int OFF_W  = 15;
  localparam int SEL_W  = 2;
  localparam int N_BANK = 1 << SEL_W;
  localparam int EN_W   = ADDR_W - OFF_W - SEL_W;

  // Bank contents, computed instead of stored
  function automatic logic [DATA_W-1:0] rom_byte(input logic [SEL_W-1:0] bank,
                                                 input logic [OFF_W-1:0] off);
    logic [DATA_W-1:0] mix;
    mix = off[7:0] ^ {1'b0, off[14:8]};
    return mix + DATA_W'(8'h47 * {6'b0, bank});
  endfunction
endpackage

// File: rtl/rom_bank_sel.sv
module rom_bank_sel
  import rom_dec_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int EW = EN_W,
  parameter int NB = 1 << SW
) (
  input  logic [SW-1:0] sel_i,
  input  logic [EW-1:0] en_bits_i,
  output logic [NB-1:0] cs_no
);
  logic region_hit;
  assign region_hit = &en_bits_i;

  for (genvar k = 0; k < NB; k++) begin : g_dec
    assign cs_no[k] = ~(region_hit && (sel_i == SW'(k)));
  end
endmodule

// File: rtl/rom_bank.sv
module rom_bank
  import rom_dec_pkg::*;
#(
  parameter int BANK_ID = 0,
  parameter int OW      = OFF_W,
  parameter int DW      = DATA_W
) (
  input  logic          cs_ni,
  input  logic          oe_ni,
  input  logic [OW-1:0] off_i,
  output logic [DW-1:0] data_o,
  output logic          drive_o
);
  assign drive_o = ~cs_ni & ~oe_ni;
  assign data_o  = drive_o ? rom_byte(SEL_W'(BANK_ID), off_i) : '0;
endmodule

// File: rtl/rom_bus_mux.sv
module rom_bus_mux
  import rom_dec_pkg::*;
#(
  parameter int NB = N_BANK,
  parameter int DW = DATA_W
) (
  input  logic [NB-1:0][DW-1:0] bank_data_i,
  input  logic [NB-1:0]         bank_drive_i,
  output logic [DW-1:0]         data_o,
  output logic                  data_oe_o
);
  // Released banks present zero, so OR acts as the shared bus
  always_comb begin
    data_o = '0;
    for (int k = 0; k < NB; k++) data_o |= bank_data_i[k];
  end
  assign data_oe_o = |bank_drive_i;
endmodule

// File: rtl/rom_bank_decoder.sv
module rom_bank_decoder
  import rom_dec_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int OW = OFF_W,
  parameter int SW = SEL_W,
  localparam int NB = 1 << SW,
  localparam int EW = AW - OW - SW
) (
  input  logic [AW-1:0] addr_i,
  input  logic          rd_ni,
  output logic [NB-1:0] cs_no,
  output logic [NB-1:0] oe_no,
  output logic [OW-1:0] bank_addr_o,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o
);
  logic [NB-1:0][DW-1:0] bank_data;
  logic [NB-1:0]         bank_drive;

  assign bank_addr_o = addr_i[OW-1:0];
  assign oe_no       = {NB{rd_ni}};

  rom_bank_sel #(.SW(SW), .EW(EW), .NB(NB)) i_sel (
    .sel_i     (addr_i[OW+SW-1:OW]),
    .en_bits_i (addr_i[AW-1:OW+SW]),
    .cs_no     (cs_no)
  );

  for (genvar k = 0; k < NB; k++) begin : g_bank
    rom_bank #(.BANK_ID(k), .OW(OW), .DW(DW)) i_bank (
      .cs_ni   (cs_no[k]),
      .oe_ni   (oe_no[k]),
      .off_i   (bank_addr_o),
      .data_o  (bank_data[k]),
      .drive_o (bank_drive[k])
    );
  end

  rom_bus_mux #(.NB(NB), .DW(DW)) i_mux (
    .bank_data_i  (bank_data),
    .bank_drive_i (bank_drive),
    .data_o       (data_o),
    .data_oe_o    (data_oe_o)
  );
endmodule

// File: rtl/rom_bank_decoder_chk.sv
module rom_bank_decoder_chk #(
  parameter int AW = 20,
  parameter int DW = 8,
  parameter int OW = 15,
  parameter int SW = 2,
  localparam int NB = 1 << SW,
  localparam int EW = AW - OW - SW
) (
  input logic [AW-1:0] addr_i,
  input logic          rd_ni,
  input logic [NB-1:0] cs_no,
  input logic [NB-1:0] oe_no,
  input logic [OW-1:0] bank_addr_o,
  input logic [DW-1:0] data_o,
  input logic          data_oe_o
);
  always_comb begin
    AST_CS_ONEHOT: assert ($onehot0(~cs_no)); // R3
    AST_CS_REGION: assert ((&addr_i[AW-1:AW-EW]) || (&cs_no)); // R2
    AST_OE_FOLLOW: assert (oe_no == {NB{rd_ni}}); // R4
    AST_DRIVE_EN:  assert (data_oe_o == (!rd_ni && !(&cs_no))); // R5
    AST_BUS_IDLE:  assert (data_oe_o || (data_o == '0)); // R7
    AST_OFF_PASS:  assert (bank_addr_o == addr_i[OW-1:0]); // R1
  end
endmodule

bind rom_bank_decoder rom_bank_decoder_chk #(.AW(AW), .DW(DW), .OW(OW), .SW(SW)) i_chk (.*);

// File: tb/test_rom_bank_decoder.sv
module test_rom_bank_decoder;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [19:0] addr;
    logic        rd_n;
  } item_t;

  logic        clk = 0;
  logic [19:0] addr_i = '0;
  logic        rd_ni  = 1'b1;
  logic [3:0]  cs_no, oe_no;
  logic [14:0] bank_addr_o;
  logic [7:0]  data_o;
  logic        data_oe_o;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rom_bank_decoder i_rom_bank_decoder (
    .addr_i(addr_i), .rd_ni(rd_ni), .cs_no(cs_no), .oe_no(oe_no),
    .bank_addr_o(bank_addr_o), .data_o(data_o), .data_oe_o(data_oe_o)
  );

  function automatic logic [7:0] exp_byte(logic [1:0] b, logic [14:0] o);
    logic [7:0] m;
    m = o[7:0] ^ {1'b0, o[14:8]};
    return m + 8'(8'h47 * b);
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Driver: apply at posedge, push expectation
  task automatic drive(logic [19:0] a, logic r);
    item_t it;
    @(posedge clk);
    addr_i = a;
    rd_ni  = r;
    it.addr = a;
    it.rd_n = r;
    q.push_back(it);
  endtask

  // Monitor: settle by negedge, pop and compare
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [3:0] e_cs;
      logic       hit, e_oe;
      logic [7:0] e_dat;
      it  = q.pop_front();
      hit = (it.addr[19:17] == 3'b111);
      e_cs = hit ? ~(4'b0001 << it.addr[16:15]) : 4'hF;
      e_oe = hit && !it.rd_n;
      e_dat = e_oe ? exp_byte(it.addr[16:15], it.addr[14:0]) : 8'h00;
      chk(bank_addr_o == it.addr[14:0], "R1 offset", 32'(bank_addr_o), 32'(it.addr[14:0]));
      chk(cs_no == e_cs, hit ? "R2 chip select" : "R3 no select outside", 32'(cs_no), 32'(e_cs));
      chk(oe_no == {4{it.rd_n}}, "R4 output enable", 32'(oe_no), 32'({4{it.rd_n}}));
      chk(data_oe_o == e_oe, "R5 drive enable", 32'(data_oe_o), 32'(e_oe));
      chk(data_o == e_dat, e_oe ? "R6 read data" : "R7 released bus", 32'(data_o), 32'(e_dat));
    end
  end

  initial begin
    // Idle state before any access: strobe high, nothing driven (R7)
    drive(20'h00000, 1'b1);
    // R8 bank edges
    drive(20'hDFFFF, 1'b0);
    drive(20'hE0000, 1'b0);
    drive(20'hE7FFF, 1'b0);
    drive(20'hE8000, 1'b0);
    drive(20'hEFFFF, 1'b0);
    drive(20'hF0000, 1'b0);
    drive(20'hF7FFF, 1'b0);
    drive(20'hF8000, 1'b0);
    drive(20'hFFFFF, 1'b0);
    // Strobe high inside region: selected but not driving (R5, R7)
    drive(20'hF1234, 1'b1);
    drive(20'h1F555, 1'b0);
    for (int i = 0; i < 400; i++) begin
      logic [19:0] a;
      a = 20'(i * 20'h1A3C5 + 20'h5B1);
      if (i % 3 != 0) a[19:17] = 3'b111;
      drive(a, (i % 7 == 0));
    end
    @(posedge clk);
    @(posedge clk);
    done = 1;
  end

  always @(posedge clk) begin
    cycles++;
    if (done) begin
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end else if (cycles > 20000) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=%0d exp=done", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule